// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the device-side bookkeeping for three circular descriptor rings that live in host memory: a request ring that the host fills, a completion ring that the device fills, and a message ring that the device fills for asynchronous events. Each ring is spread over separately addressed pages. The block holds a page table per ring, a power-of-two index mask per ring and its own free-running 32-bit pointers. From these it produces the 64-bit physical address of the next descriptor to read or write. It also decides whether a request is waiting or the message ring has room, and it issues 32-bit writes of producer, consumer and size fields into a shared ring-state area in host memory.

Software loads page numbers through a page-table port, then starts a data-ring setup (request and completion together, plus the ring-state page) or a message-ring setup. A setup with a bad page count is refused and leaves all state alone. A message-ring setup is refused until the data rings are ready. When both setup strobes are high in the same cycle, only the data-ring setup is acted on. The datapath pops descriptors one per cycle and strobes a flush after a batch so that the matching index is published. Ring-state writes leave on a single write port, one per cycle, and the port never stalls.

Top module: `ring_index_mgr`

## Requirements
- R1: A data setup with N request pages and M completion pages writes size exponents equal to the bit length of (N*32 - 1) and of (M*128 - 1). A message setup with K pages writes the bit length of (K*64 - 1). Each ring's index mask is all ones over that many bits.
- R2: A page base is its page number shifted left by 12. The descriptor address is the base of page (masked index / entries per page) plus (masked index mod entries per page) times the descriptor size. Request, completion and message descriptors are 128, 32 and 64 bytes, with 32, 128 and 64 entries per page.
- R3: req_avail is high only when the data rings are ready, host_req_prod differs from the internal consumed pointer, and (host_req_prod - consumed) mod 2^32 is below 1024. A req_pop while req_avail is low leaves req_addr unchanged.
- R4: Each accepted pop advances that ring's pointer by one. The address wraps to index 0 after mask+1 pops.
- R5: The request consumer index is written only on req_flush, at ring-state offset 0x04, with the full consumed count.
- R6: Completion pops are never refused once the data rings are ready. cmp_flush publishes the completion producer count at offset 0x0C.
- R7: msg_room is high only after a successful message setup and while (published message producer - host_msg_cons) mod 2^32 is below mask+1. msg_flush publishes the message producer at offset 0x18.
- R8: A setup with a page count of 0, or above 32 (data) or 16 (message), or a message setup before the data rings are ready, pulses cfg_err and changes no state and writes nothing.
- R9: An accepted data setup pulses cfg_ok and then writes on six consecutive cycles at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (request producer 0, request consumer 0, request exponent, completion producer 0, completion consumer 0, completion exponent). An accepted message setup writes at 0x18, 0x1C and 0x20 (producer 0, consumer 0, exponent). The ring-state base is the ring-state page number shifted left by 12.
- R10: Reset clears the ready flags, masks, pointers, page tables and pending writes. After reset all descriptor addresses read 0 and no write is issued.
- R11: The write port issues at most one write per cycle. Pending fields go out lowest offset first, so flushes of all three rings strobed together leave at 0x04, then 0x0C, then 0x18 on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_we | input | 1 | Page-table write strobe |
| pt_ring | input | 2 | Target ring: 0 request, 1 completion, 2 message |
| pt_idx | input | 5 | Page slot in the target ring |
| pt_ppn | input | 64 | Physical page number for the slot |
| cfg_data_go | input | 1 | Start request and completion ring setup |
| cfg_msg_go | input | 1 | Start message ring setup |
| cfg_req_pages | input | 8 | Request ring page count |
| cfg_cmp_pages | input | 8 | Completion ring page count |
| cfg_msg_pages | input | 8 | Message ring page count |
| cfg_state_ppn | input | 64 | Page number of the ring-state area |
| cfg_ok | output | 1 | One-cycle pulse: setup accepted |
| cfg_err | output | 1 | One-cycle pulse: setup refused |
| data_ready | output | 1 | Request and completion rings set up |
| msg_ready | output | 1 | Message ring set up |
| host_req_prod | input | 32 | Host request producer index |
| req_avail | output | 1 | A request descriptor is waiting |
| req_pop | input | 1 | Consume the current request descriptor |
| req_addr | output | 64 | Address of the current request descriptor |
| req_flush | input | 1 | Publish the request consumer index |
| cmp_pop | input | 1 | Claim the current completion slot |
| cmp_addr | output | 64 | Address of the current completion slot |
| cmp_flush | input | 1 | Publish the completion producer index |
| host_msg_cons | input | 32 | Host message consumer index |
| msg_room | output | 1 | The message ring has a free slot |
| msg_pop | input | 1 | Claim the current message slot |
| msg_addr | output | 64 | Address of the current message slot |
| msg_flush | input | 1 | Publish the message producer index |
| rs_wr_valid | output | 1 | Ring-state write this cycle |
| rs_wr_addr | output | 64 | Ring-state write address |
| rs_wr_data | output | 32 | Ring-state write data |

## Verification
On every cycle the assertions hold the gating rules: no request or room indication without the matching ready flag, a message ring that is never ready without the data rings, a request address that does not move without a pop, page write or setup, an accepted setup followed at once by a write, a refused setup that leaves the ready flags alone, and a quiet write port after reset. The exact exponents, descriptor addresses across page boundaries and the ring wrap depend on the chosen page counts. So do the modular limits of the availability and room tests and the order of queued ring-state writes. Only the bench's scenarios show these, by comparing against values computed from the requirements.

// File: rtl/ring_pkg.sv
// Shared definitions for the ring index manager.
// Assumes ring-state fields are 32-bit words at consecutive 4-byte offsets.
package ring_pkg;
    localparam int FIELD_N = 9;

    // Ring-state fields; the value times 4 is the byte offset in the area
    typedef enum logic [3:0] {
        F_REQ_PROD = 4'd0,
        F_REQ_CONS = 4'd1,
        F_REQ_EXP  = 4'd2,
        F_CMP_PROD = 4'd3,
        F_CMP_CONS = 4'd4,
        F_CMP_EXP  = 4'd5,
        F_MSG_PROD = 4'd6,
        F_MSG_CONS = 4'd7,
        F_MSG_EXP  = 4'd8
    } rs_field_e;

    // Number of bits needed to hold v (0 for v == 0)
    function automatic logic [31:0] bit_len(input logic [31:0] v);
        logic [31:0] n;
        n = '0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) n = 32'(i + 1);
        end
        return n;
    endfunction

    // All ones over the lowest e bits
    function automatic logic [31:0] exp_mask(input logic [31:0] e);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (32'(i) < e) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ring_lane.sv
// One ring: page table, index mask and free-running pointer, plus the
// descriptor address for the current pointer.
// Assumes MAX_PAGES and ENTRIES_PER_PAGE are powers of two (MAX_PAGES >= 2),
// so a masked index always selects an existing page slot.
module ring_lane #(
    parameter int PAGE_SHIFT       = 12,
    parameter int MAX_PAGES        = 32,
    parameter int ENTRIES_PER_PAGE = 32,
    parameter int DESC_BYTES       = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pt_we,
    input  logic [$clog2(MAX_PAGES)-1:0] pt_idx,
    input  logic [63:0]                  pt_ppn,
    input  logic                         init,
    input  logic [31:0]                  init_mask,
    input  logic                         step,
    output logic [31:0]                  ptr,
    output logic [63:0]                  desc_addr
);
    localparam int PW = $clog2(MAX_PAGES);
    localparam int EW = $clog2(ENTRIES_PER_PAGE);
    localparam int IW = PW + EW;

    logic [63:0] base_q [MAX_PAGES];
    logic [31:0] mask_q;
    logic [31:0] ptr_q;
    logic [IW-1:0] idx;
    logic [PW-1:0] page;
    logic [EW-1:0] slot;

    // Page table, mask and pointer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_PAGES; i++) base_q[i] <= '0;
            mask_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (pt_we) base_q[pt_idx] <= pt_ppn << PAGE_SHIFT;
            if (init) begin
                mask_q <= init_mask;
                ptr_q  <= '0;
            end else if (step) begin
                ptr_q <= ptr_q + 32'd1;
            end
        end
    end

    // Split the masked index into page slot and in-page entry
    always_comb begin
        idx       = IW'(ptr_q & mask_q);
        page      = idx[IW-1:EW];
        slot      = idx[EW-1:0];
        desc_addr = base_q[page] + (64'(slot) * 64'(DESC_BYTES));
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rs_writer.sv
// Ring-state write queue: one pending bit per field, issued lowest field
// first, one per cycle. Data is taken from the live value at issue time.
// Assumes the downstream port accepts a write every cycle.
module rs_writer #(
    parameter int N = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           set,
    input  logic [N-1:0][31:0]     val,
    output logic                   wr_valid,
    output logic [$clog2(N)-1:0]   wr_sel,
    output logic [31:0]            wr_data
);
    localparam int SW = $clog2(N);

    logic [N-1:0] pend_q;
    logic [N-1:0] grant;

    // Pick the lowest pending field
    always_comb begin
        grant  = pend_q & (~pend_q + N'(1));
        wr_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) wr_sel = SW'(i);
        end
        wr_valid = |pend_q;
        wr_data  = val[wr_sel];
    end

    // Retire the granted field; a new request for it stays pending
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant) | set;
    end
endmodule

// File: rtl/ring_index_mgr.sv
// Index manager for request, completion and message descriptor rings held
// in paged host memory. Validates setup, generates descriptor addresses,
// tests availability and room, and queues ring-state index writes.
// Assumes pops happen at most once per cycle per ring and that the caller
// flushes the message ring after each message it writes.
module ring_index_mgr #(
    parameter int PAGE_SHIFT    = 12,
    parameter int RING_MAX_PAGES = 32,
    parameter int MSG_MAX_PAGES = 16,
    parameter int REQ_EPP       = 32,
    parameter int CMP_EPP       = 128,
    parameter int MSG_EPP       = 64,
    parameter int REQ_BYTES     = 128,
    parameter int CMP_BYTES     = 32,
    parameter int MSG_BYTES     = 64,
    parameter int CNT_W         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pt_we,
    input  logic [1:0]                        pt_ring,
    input  logic [$clog2(RING_MAX_PAGES)-1:0] pt_idx,
    input  logic [63:0]                       pt_ppn,
    input  logic                              cfg_data_go,
    input  logic                              cfg_msg_go,
    input  logic [CNT_W-1:0]                  cfg_req_pages,
    input  logic [CNT_W-1:0]                  cfg_cmp_pages,
    input  logic [CNT_W-1:0]                  cfg_msg_pages,
    input  logic [63:0]                       cfg_state_ppn,
    output logic                              cfg_ok,
    output logic                              cfg_err,
    output logic                              data_ready,
    output logic                              msg_ready,
    input  logic [31:0]                       host_req_prod,
    output logic                              req_avail,
    input  logic                              req_pop,
    output logic [63:0]                       req_addr,
    input  logic                              req_flush,
    input  logic                              cmp_pop,
    output logic [63:0]                       cmp_addr,
    input  logic                              cmp_flush,
    input  logic [31:0]                       host_msg_cons,
    output logic                              msg_room,
    input  logic                              msg_pop,
    output logic [63:0]                       msg_addr,
    input  logic                              msg_flush,
    output logic                              rs_wr_valid,
    output logic [63:0]                       rs_wr_addr,
    output logic [31:0]                       rs_wr_data
);
    import ring_pkg::*;

    localparam int MPW         = $clog2(MSG_MAX_PAGES);
    localparam int SW          = $clog2(FIELD_N);
    localparam logic [31:0] REQ_LIMIT = 32'(RING_MAX_PAGES * REQ_EPP);

    logic        data_ready_q, msg_ready_q, cfg_ok_q, cfg_err_q;
    logic [63:0] rs_base_q;
    logic [31:0] req_exp_q, cmp_exp_q, msg_exp_q, msg_pub_q;
    logic [31:0] req_exp_n, cmp_exp_n, msg_exp_n;
    logic [31:0] req_ptr, cmp_ptr, msg_ptr;
    logic        data_cfg_good, msg_cfg_good, data_init, msg_init, msg_go_eff;
    logic        req_step, cmp_step, msg_step;
    logic        pt_req_we, pt_cmp_we, pt_msg_we;
    logic [FIELD_N-1:0]        rs_set;
    logic [FIELD_N-1:0][31:0]  rs_val;
    logic [SW-1:0]             rs_sel;

    // Setup validation and exponent computation
    always_comb begin
        req_exp_n = bit_len(32'(cfg_req_pages) * 32'(REQ_EPP) - 32'd1);
        cmp_exp_n = bit_len(32'(cfg_cmp_pages) * 32'(CMP_EPP) - 32'd1);
        msg_exp_n = bit_len(32'(cfg_msg_pages) * 32'(MSG_EPP) - 32'd1);
        data_cfg_good = (cfg_req_pages != '0) && (32'(cfg_req_pages) <= 32'(RING_MAX_PAGES))
                     && (cfg_cmp_pages != '0) && (32'(cfg_cmp_pages) <= 32'(RING_MAX_PAGES));
        msg_cfg_good  = data_ready_q && (cfg_msg_pages != '0)
                     && (32'(cfg_msg_pages) <= 32'(MSG_MAX_PAGES));
        msg_go_eff = cfg_msg_go && !cfg_data_go;
        data_init  = cfg_data_go && data_cfg_good;
        msg_init   = msg_go_eff && msg_cfg_good;
    end

    // Availability, room and pop acceptance
    always_comb begin
        req_avail = data_ready_q && (host_req_prod != req_ptr)
                 && ((host_req_prod - req_ptr) < REQ_LIMIT);
        msg_room  = msg_ready_q
                 && ((msg_pub_q - host_msg_cons) < (exp_mask(msg_exp_q) + 32'd1));
        req_step  = req_pop && req_avail;
        cmp_step  = cmp_pop && data_ready_q;
        msg_step  = msg_pop && msg_room;
        pt_req_we = pt_we && (pt_ring == 2'd0);
        pt_cmp_we = pt_we && (pt_ring == 2'd1);
        pt_msg_we = pt_we && (pt_ring == 2'd2) && (32'(pt_idx) < 32'(MSG_MAX_PAGES));
    end

    // Configuration registers and the published message producer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ready_q <= 1'b0;
            msg_ready_q  <= 1'b0;
            cfg_ok_q     <= 1'b0;
            cfg_err_q    <= 1'b0;
            rs_base_q    <= '0;
            req_exp_q    <= '0;
            cmp_exp_q    <= '0;
            msg_exp_q    <= '0;
            msg_pub_q    <= '0;
        end else begin
            cfg_ok_q  <= data_init || msg_init;
            cfg_err_q <= (cfg_data_go && !data_cfg_good) || (msg_go_eff && !msg_cfg_good);
            if (data_init) begin
                data_ready_q <= 1'b1;
                rs_base_q    <= cfg_state_ppn << PAGE_SHIFT;
                req_exp_q    <= req_exp_n;
                cmp_exp_q    <= cmp_exp_n;
            end
            if (msg_init) begin
                msg_ready_q <= 1'b1;
                msg_exp_q   <= msg_exp_n;
                msg_pub_q   <= '0;
            end else if (rs_wr_valid && (rs_sel == SW'(F_MSG_PROD))) begin
                msg_pub_q <= msg_ptr;
            end
        end
    end

    // Ring-state field requests and live values
    always_comb begin
        rs_set = '0;
        if (data_init) begin
            rs_set[F_REQ_PROD] = 1'b1;
            rs_set[F_REQ_CONS] = 1'b1;
            rs_set[F_REQ_EXP]  = 1'b1;
            rs_set[F_CMP_PROD] = 1'b1;
            rs_set[F_CMP_CONS] = 1'b1;
            rs_set[F_CMP_EXP]  = 1'b1;
        end
        if (msg_init) begin
            rs_set[F_MSG_PROD] = 1'b1;
            rs_set[F_MSG_CONS] = 1'b1;
            rs_set[F_MSG_EXP]  = 1'b1;
        end
        if (req_flush && data_ready_q) rs_set[F_REQ_CONS] = 1'b1;
        if (cmp_flush && data_ready_q) rs_set[F_CMP_PROD] = 1'b1;
        if (msg_flush && msg_ready_q)  rs_set[F_MSG_PROD] = 1'b1;
        rs_val             = '0;
        rs_val[F_REQ_CONS] = req_ptr;
        rs_val[F_REQ_EXP]  = req_exp_q;
        rs_val[F_CMP_PROD] = cmp_ptr;
        rs_val[F_CMP_EXP]  = cmp_exp_q;
        rs_val[F_MSG_PROD] = msg_ptr;
        rs_val[F_MSG_EXP]  = msg_exp_q;
    end

    ring_lane #(.PAGE_SHIFT(PAGE_SHIFT), .MAX_PAGES(RING_MAX_PAGES),
                .ENTRIES_PER_PAGE(REQ_EPP), .DESC_BYTES(REQ_BYTES)) u_req (
        .clk(clk), .rst_n(rst_n), .pt_we(pt_req_we), .pt_idx(pt_idx), .pt_ppn(pt_ppn),
        .init(data_init), .init_mask(exp_mask(req_exp_n)), .step(req_step),
        .ptr(req_ptr), .desc_addr(req_addr));

    ring_lane #(.PAGE_SHIFT(PAGE_SHIFT), .MAX_PAGES(RING_MAX_PAGES),
                .ENTRIES_PER_PAGE(CMP_EPP), .DESC_BYTES(CMP_BYTES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .pt_we(pt_cmp_we), .pt_idx(pt_idx), .pt_ppn(pt_ppn),
        .init(data_init), .init_mask(exp_mask(cmp_exp_n)), .step(cmp_step),
        .ptr(cmp_ptr), .desc_addr(cmp_addr));

    ring_lane #(.PAGE_SHIFT(PAGE_SHIFT), .MAX_PAGES(MSG_MAX_PAGES),
                .ENTRIES_PER_PAGE(MSG_EPP), .DESC_BYTES(MSG_BYTES)) u_msg (
        .clk(clk), .rst_n(rst_n), .pt_we(pt_msg_we), .pt_idx(pt_idx[MPW-1:0]), .pt_ppn(pt_ppn),
        .init(msg_init), .init_mask(exp_mask(msg_exp_n)), .step(msg_step),
        .ptr(msg_ptr), .desc_addr(msg_addr));

    rs_writer #(.N(FIELD_N)) u_wr (
        .clk(clk), .rst_n(rst_n), .set(rs_set), .val(rs_val),
        .wr_valid(rs_wr_valid), .wr_sel(rs_sel), .wr_data(rs_wr_data));

    assign rs_wr_addr = rs_base_q + 64'({rs_sel, 2'b00});
    assign cfg_ok     = cfg_ok_q;
    assign cfg_err    = cfg_err_q;
    assign data_ready = data_ready_q;
    assign msg_ready  = msg_ready_q;
endmodule

// File: rtl/ring_index_chk.sv
// Cycle-by-cycle checks on the ring index manager's ports.
module ring_index_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pt_we,
    input logic        cfg_data_go,
    input logic        cfg_ok,
    input logic        cfg_err,
    input logic        data_ready,
    input logic        msg_ready,
    input logic        req_avail,
    input logic        req_pop,
    input logic [63:0] req_addr,
    input logic        msg_room,
    input logic        rs_wr_valid
);
    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_avail |-> data_ready);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pop && !pt_we && !cfg_data_go) |=> $stable(req_addr));

    // R7
    msg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_room |-> msg_ready);

    // R7
    msg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> data_ready);

    // R8
    reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($stable(data_ready) && $stable(msg_ready)));

    // R9
    setup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> rs_wr_valid);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!data_ready && !msg_ready && !rs_wr_valid && !cfg_ok && !cfg_err));
endmodule

bind ring_index_mgr ring_index_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pt_we(pt_we), .cfg_data_go(cfg_data_go),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .data_ready(data_ready), .msg_ready(msg_ready),
    .req_avail(req_avail), .req_pop(req_pop), .req_addr(req_addr),
    .msg_room(msg_room), .rs_wr_valid(rs_wr_valid));

// File: tb/sim_ring_index_mgr.sv
`timescale 1ns/1ps
module sim_ring_index_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pt_we = 1'b0;
    logic [1:0]  pt_ring = '0;
    logic [4:0]  pt_idx = '0;
    logic [63:0] pt_ppn = '0;
    logic        cfg_data_go = 1'b0, cfg_msg_go = 1'b0;
    logic [7:0]  cfg_req_pages = '0, cfg_cmp_pages = '0, cfg_msg_pages = '0;
    logic [63:0] cfg_state_ppn = 64'h50;
    logic        cfg_ok, cfg_err, data_ready, msg_ready;
    logic [31:0] host_req_prod = '0;
    logic        req_avail, req_pop = 1'b0, req_flush = 1'b0;
    logic [63:0] req_addr, cmp_addr, msg_addr;
    logic        cmp_pop = 1'b0, cmp_flush = 1'b0;
    logic [31:0] host_msg_cons = '0;
    logic        msg_room, msg_pop = 1'b0, msg_flush = 1'b0;
    logic        rs_wr_valid;
    logic [63:0] rs_wr_addr;
    logic [31:0] rs_wr_data;

    localparam logic [63:0] RS_BASE = 64'h50000;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ring_index_mgr u0 (
        .clk(clk), .rst_n(rst_n), .pt_we(pt_we), .pt_ring(pt_ring), .pt_idx(pt_idx),
        .pt_ppn(pt_ppn), .cfg_data_go(cfg_data_go), .cfg_msg_go(cfg_msg_go),
        .cfg_req_pages(cfg_req_pages), .cfg_cmp_pages(cfg_cmp_pages),
        .cfg_msg_pages(cfg_msg_pages), .cfg_state_ppn(cfg_state_ppn),
        .cfg_ok(cfg_ok), .cfg_err(cfg_err), .data_ready(data_ready), .msg_ready(msg_ready),
        .host_req_prod(host_req_prod), .req_avail(req_avail), .req_pop(req_pop),
        .req_addr(req_addr), .req_flush(req_flush), .cmp_pop(cmp_pop), .cmp_addr(cmp_addr),
        .cmp_flush(cmp_flush), .host_msg_cons(host_msg_cons), .msg_room(msg_room),
        .msg_pop(msg_pop), .msg_addr(msg_addr), .msg_flush(msg_flush),
        .rs_wr_valid(rs_wr_valid), .rs_wr_addr(rs_wr_addr), .rs_wr_data(rs_wr_data));

    // Setup vectors: request pages, completion pages, accepted, exponents
    localparam int TV_N = 6;
    localparam int TV_RP [TV_N] = '{1, 2, 3, 0, 4, 32};
    localparam int TV_CP [TV_N] = '{1, 4, 1, 2, 33, 32};
    localparam int TV_OK [TV_N] = '{1, 1, 1, 0, 0, 1};
    localparam int TV_RE [TV_N] = '{5, 6, 7, 0, 0, 10};
    localparam int TV_CE [TV_N] = '{7, 9, 7, 0, 0, 12};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_wr(input string req, input logic [63:0] ofs, input logic [31:0] data);
        check(req, {63'd0, rs_wr_valid}, 64'd1);
        check(req, rs_wr_addr, RS_BASE + ofs);
        check(req, {32'd0, rs_wr_data}, {32'd0, data});
    endtask

    task automatic load_pt(input logic [1:0] ring, input logic [4:0] idx, input logic [63:0] ppn);
        pt_we = 1'b1; pt_ring = ring; pt_idx = idx; pt_ppn = ppn;
        tick();
        pt_we = 1'b0;
    endtask

    task automatic pops(input int n, input bit which_req, input bit which_cmp, input bit which_msg);
        req_pop = which_req; cmp_pop = which_cmp; msg_pop = which_msg;
        repeat (n) tick();
        req_pop = 1'b0; cmp_pop = 1'b0; msg_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R10 reset state
        check("R10", {62'd0, data_ready, msg_ready}, 64'd0);
        check("R10", {63'd0, rs_wr_valid}, 64'd0);
        check("R10", req_addr, 64'd0);
        rst_n = 1'b1;
        tick();

        // R8 message setup before data rings
        cfg_msg_go = 1'b1; cfg_msg_pages = 8'd1;
        tick();
        cfg_msg_go = 1'b0;
        check("R8", {62'd0, cfg_err, msg_ready}, 64'd2);
        check("R8", {63'd0, rs_wr_valid}, 64'd0);

        // R1 R8 R9 setup vector table
        for (int v = 0; v < TV_N; v++) begin
            cfg_req_pages = 8'(TV_RP[v]); cfg_cmp_pages = 8'(TV_CP[v]);
            cfg_data_go = 1'b1;
            tick();
            cfg_data_go = 1'b0;
            if (TV_OK[v] == 1) begin
                check("R9", {62'd0, cfg_ok, cfg_err}, 64'd2);
                check_wr("R9", 64'h00, 32'd0);
                tick(); check_wr("R9", 64'h04, 32'd0);
                tick(); check_wr("R1", 64'h08, 32'(TV_RE[v]));
                tick(); check_wr("R9", 64'h0C, 32'd0);
                tick(); check_wr("R9", 64'h10, 32'd0);
                tick(); check_wr("R1", 64'h14, 32'(TV_CE[v]));
                tick();
                check("R9", {63'd0, rs_wr_valid}, 64'd0);
            end else begin
                check("R8", {62'd0, cfg_ok, cfg_err}, 64'd1);
                check("R8", {63'd0, data_ready}, 64'd1);
                check("R8", {63'd0, rs_wr_valid}, 64'd0);
            end
        end

        // Page tables for directed tests
        load_pt(2'd0, 5'd0, 64'h100);
        load_pt(2'd0, 5'd1, 64'h200);
        load_pt(2'd1, 5'd0, 64'h300);
        load_pt(2'd2, 5'd0, 64'h400);
        cfg_req_pages = 8'd2; cfg_cmp_pages = 8'd1;
        cfg_data_go = 1'b1;
        tick();
        cfg_data_go = 1'b0;
        repeat (6) tick();

        // R3 nothing waiting, pop ignored
        check("R3", {63'd0, req_avail}, 64'd0);
        pops(2, 1'b1, 1'b0, 1'b0);
        check("R3", req_addr, 64'h100000);
        host_req_prod = 32'd100;
        #1;
        check("R3", {63'd0, req_avail}, 64'd1);
        // R2 R4 addresses across pages and wrap
        pops(1, 1'b1, 1'b0, 1'b0);
        check("R2", req_addr, 64'h100080);
        pops(31, 1'b1, 1'b0, 1'b0);
        check("R2", req_addr, 64'h200000);
        pops(32, 1'b1, 1'b0, 1'b0);
        check("R4", req_addr, 64'h100000);
        check("R5", {63'd0, rs_wr_valid}, 64'd0);
        // R3 modular window
        host_req_prod = 32'd64 + 32'd1024; #1;
        check("R3", {63'd0, req_avail}, 64'd0);
        host_req_prod = 32'd64 + 32'd1023; #1;
        check("R3", {63'd0, req_avail}, 64'd1);
        host_req_prod = 32'd63; #1;
        check("R3", {63'd0, req_avail}, 64'd0);
        // R5 consumer publish
        req_flush = 1'b1; tick(); req_flush = 1'b0;
        check_wr("R5", 64'h04, 32'd64);
        tick();

        // R6 completion pops and publish
        check("R6", cmp_addr, 64'h300000);
        pops(3, 1'b0, 1'b1, 1'b0);
        check("R6", cmp_addr, 64'h300060);
        cmp_flush = 1'b1; tick(); cmp_flush = 1'b0;
        check_wr("R6", 64'h0C, 32'd3);
        tick();

        // R7 message ring
        check("R7", {63'd0, msg_room}, 64'd0);
        cfg_msg_go = 1'b1; cfg_msg_pages = 8'd0;
        tick();
        check("R8", {62'd0, cfg_err, msg_ready}, 64'd2);
        cfg_msg_pages = 8'd1;
        tick();
        cfg_msg_go = 1'b0;
        check_wr("R9", 64'h18, 32'd0);
        tick(); check_wr("R9", 64'h1C, 32'd0);
        tick(); check_wr("R1", 64'h20, 32'd6);
        tick();
        check("R7", {63'd0, msg_room}, 64'd1);
        check("R2", msg_addr, 64'h400000);
        pops(1, 1'b0, 1'b0, 1'b1);
        check("R2", msg_addr, 64'h400040);
        msg_flush = 1'b1; tick(); msg_flush = 1'b0;
        check_wr("R7", 64'h18, 32'd1);
        tick();
        host_msg_cons = 32'hFFFF_FFC1; #1;
        check("R7", {63'd0, msg_room}, 64'd0);
        host_msg_cons = 32'hFFFF_FFC2; #1;
        check("R7", {63'd0, msg_room}, 64'd1);

        // R11 simultaneous flushes
        req_flush = 1'b1; cmp_flush = 1'b1; msg_flush = 1'b1;
        tick();
        req_flush = 1'b0; cmp_flush = 1'b0; msg_flush = 1'b0;
        check_wr("R11", 64'h04, 32'd64);
        tick(); check_wr("R11", 64'h0C, 32'd3);
        tick(); check_wr("R11", 64'h18, 32'd1);
        tick();
        check("R11", {63'd0, rs_wr_valid}, 64'd0);

        // R10 reset mid-run
        rst_n = 1'b0;
        tick();
        check("R10", {62'd0, data_ready, msg_ready}, 64'd0);
        check("R10", req_addr, 64'd0);
        check("R10", cmp_addr, 64'd0);
        check("R10", msg_addr, 64'd0);
        rst_n = 1'b1;
        tick();
        check("R10", {61'd0, req_avail, msg_room, rs_wr_valid}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule